// File: doc/BRIEF.md
# SDIO Card Interrupt Detector

This block watches the DAT[1] line of an SD bus and raises a host interrupt request when an attached SDIO card asks for service. In the single-data-line bus mode, DAT[1] carries no data. A low level on it is a live request that lasts as long as the card holds the line low. In the four-data-line bus mode, DAT[1] carries data while a transfer runs. The card may then signal only inside a short interrupt window that follows each 512-byte block. A sampled low in that window sets a sticky flag, which software clears. When the four-line bus is idle, the line is read as a level request, as in single-line mode.

The block keeps its own per-block byte counter, which is driven by a byte strobe from the data path. The counter produces the block-boundary event that arms the interrupt window. A read-wait request freezes the counter and the window timer and tells the data counters to pause. The bus clock keeps running during the pause, so commands can be sent on the bus. When read-wait is released, counting resumes from the held values. The interrupt output is the pending flag gated by an enable input.

Top module: `sdio_irq_watch`

## Requirements
- R1: When wide_mode=0, irq_pending is 1 one clock after a clock edge that samples dat1_in=0, and 0 one clock after an edge that samples dat1_in=1. This holds whatever the value of xfer_active.
- R2: When wide_mode=1 and xfer_active=0, DAT[1] is a level request that follows the same timing as R1.
- R3: When wide_mode=1 and xfer_active=1, a low dat1_in outside the interrupt window never sets irq_pending.
- R4: After the block-boundary byte, irq_window goes to 1 on the second clock edge that has sd_clk_en=1. It stays at 1 for WIN_LEN (default 1) such edges. An edge inside the window with sd_clk_en=1 and dat1_in=0 sets a sticky irq_pending, which holds after DAT[1] returns high.
- R5: While rdwait_req=1, ctr_pause=1, and byte_count and the window timer hold their values. Byte strobes have no effect during this time.
- R6: When rdwait_req returns to 0, counting resumes from the held byte_count value.
- R7: byte_count counts accepted byte_stb pulses while xfer_active=1. It steps 0 to BLOCK_BYTES-1 (default 511), and the next pulse wraps it to 0, which is the block boundary. With xfer_active=0 and rdwait_req=0, byte_count returns to 0.
- R8: irq_clear clears the sticky flag. If the clear and a window sample fall on the same edge, the clear wins.
- R9: irq_out = irq_pending AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_clk_en | input | 1 | One-cycle pulse per SD bus clock period |
| wide_mode | input | 1 | 1 = four-data-line bus, 0 = single-line bus |
| dat1_in | input | 1 | Sampled DAT[1] line level |
| xfer_active | input | 1 | A data transfer is in progress |
| byte_stb | input | 1 | One data byte moved on the bus |
| irq_en | input | 1 | Interrupt output enable |
| rdwait_req | input | 1 | Read-wait pause request |
| irq_clear | input | 1 | Clears the sticky interrupt flag |
| irq_out | output | 1 | Gated interrupt request to the host |
| ctr_pause | output | 1 | Freeze command to the data counters |
| irq_pending | output | 1 | Interrupt pending, before the enable gate |
| irq_window | output | 1 | Interrupt window is open |
| byte_count | output | CNT_W (9) | Byte position within the current block |

## Verification
Some properties are checked on every cycle. These are the level-request response in single-line mode and in idle four-line mode. They also include the byte counter range and the wrap to zero at the block boundary, and the freeze of the counter and the window timer under read-wait. The last two are that the sticky flag only ever rises from a window sample and that the clear wins over a set. Other behaviour can only be shown by the bench's scenarios. These are the exact placement of the window two SD clock ticks after the 512th byte, and the masking of a low DAT[1] during data. They also include the resumption of counting after a pause, the gating by the enable, and the persistence of the sticky flag once the line goes high.

// File: rtl/sdio_irq_pkg.sv
// Shared types for the SDIO card interrupt detector.
package sdio_irq_pkg;
    // Phases of the block-boundary interrupt window timer.
    typedef enum logic [1:0] {
        WG_IDLE  = 2'd0,
        WG_DELAY = 2'd1,
        WG_OPEN  = 2'd2
    } win_state_e;
endpackage

// File: rtl/blk_byte_ctr.sv
// Per-block byte counter.
// Counts accepted byte strobes from 0 to BLOCK_BYTES-1 and wraps. It flags
// the wrapping byte as the block boundary. A hold input freezes the count.
// With no transfer and no hold, the count returns to zero.
// Assumes: byte_stb is a single-cycle pulse per byte.
module blk_byte_ctr #(
    parameter int BLOCK_BYTES = 512,
    localparam int CNT_W = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic             hold,
    input  logic             byte_stb,
    output logic [CNT_W-1:0] cnt_o,
    output logic             blk_end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    // Purpose: a strobe counts only during a transfer that is not paused.
    always_comb begin
        accept    = byte_stb && xfer_active && !hold;
        blk_end_o = accept && (cnt_q == LAST);
    end

    // Purpose: hold, clear when idle, or advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= cnt_q;
        end else if (!xfer_active) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end_o |=> cnt_q == '0);
    a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(cnt_q));
endmodule

// File: rtl/irq_window_gen.sv
// Interrupt window timer for the four-data-line bus mode.
// After an arm pulse (block boundary), it waits WIN_DELAY SD clock ticks and
// then opens the window for WIN_LEN ticks. A tick inside the open window is
// reported as a sample point. Hold freezes the whole timer.
// Assumes: WIN_DELAY >= 1 and WIN_LEN >= 1; tick is one cycle per SD clock.
module irq_window_gen
    import sdio_irq_pkg::*;
#(
    parameter int WIN_DELAY = 2,
    parameter int WIN_LEN   = 1,
    localparam int MAXV = (WIN_DELAY > WIN_LEN) ? WIN_DELAY : WIN_LEN,
    localparam int TW   = $clog2(MAXV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic arm,
    output logic win_o,
    output logic sample_o
);
    win_state_e    state_q;
    logic [TW-1:0] left_q;

    // Purpose: arm, count down the delay, then count down the open phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WG_IDLE;
            left_q  <= '0;
        end else if (hold) begin
            state_q <= state_q;
            left_q  <= left_q;
        end else if (arm) begin
            state_q <= WG_DELAY;
            left_q  <= TW'(WIN_DELAY);
        end else if (tick) begin
            unique case (state_q)
                WG_DELAY: begin
                    if (left_q <= TW'(1)) begin
                        state_q <= WG_OPEN;
                        left_q  <= TW'(WIN_LEN);
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
                WG_OPEN: begin
                    if (left_q <= TW'(1)) begin
                        state_q <= WG_IDLE;
                        left_q  <= '0;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= WG_IDLE;
                    left_q  <= '0;
                end
            endcase
        end
    end

    // Purpose: expose the window and its sample instants.
    always_comb begin
        win_o    = (state_q == WG_OPEN);
        sample_o = win_o && tick && !hold;
    end

    a_r4_opens_from_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_o) |-> $past(state_q == WG_DELAY));
    a_r4_closes_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o && tick && !hold && !arm && left_q == TW'(1)) |=> !win_o);
    a_r5_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(state_q) && $stable(left_q)));
endmodule

// File: rtl/irq_flag_core.sv
// Interrupt flag logic.
// A level request comes from a low DAT[1] in single-line mode or on an idle
// four-line bus. A sticky flag is set by a low DAT[1] at a window sample
// point. The clear input takes priority over a new set.
// Assumes: dat1_in is already synchronous to clk.
module irq_flag_core (
    input  logic clk,
    input  logic rst_n,
    input  logic wide_mode,
    input  logic xfer_active,
    input  logic dat1_in,
    input  logic sample,
    input  logic clear,
    output logic pending_o
);
    logic level_q;
    logic sticky_q;

    // Purpose: register the live level request where DAT[1] carries no data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= !dat1_in && (!wide_mode || !xfer_active);
        end
    end

    // Purpose: sticky window capture, with the clear winning over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (clear) begin
            sticky_q <= 1'b0;
        end else if (sample && !dat1_in) begin
            sticky_q <= 1'b1;
        end
    end

    assign pending_o = level_q || sticky_q;

    a_r1_level_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && !dat1_in) |=> pending_o);
    a_r3_sticky_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q) |-> $past(sample));
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sticky_q);
endmodule

// File: rtl/sdio_irq_watch.sv
// SDIO card interrupt detector, top level.
// Connects the byte counter, the interrupt window timer and the flag logic.
// Read-wait freezes the counter and the timer, and is forwarded as the pause
// command to the data counters. The output is the pending flag gated by the
// enable input.
// Assumes: all inputs are synchronous to clk; sd_clk_en marks SD clock ticks.
module sdio_irq_watch #(
    parameter int BLOCK_BYTES = 512,
    parameter int WIN_DELAY   = 2,
    parameter int WIN_LEN     = 1,
    localparam int CNT_W = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_clk_en,
    input  logic             wide_mode,
    input  logic             dat1_in,
    input  logic             xfer_active,
    input  logic             byte_stb,
    input  logic             irq_en,
    input  logic             rdwait_req,
    input  logic             irq_clear,
    output logic             irq_out,
    output logic             ctr_pause,
    output logic             irq_pending,
    output logic             irq_window,
    output logic [CNT_W-1:0] byte_count
);
    logic blk_end;
    logic win_sample;

    blk_byte_ctr #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_active(xfer_active),
        .hold       (rdwait_req),
        .byte_stb   (byte_stb),
        .cnt_o      (byte_count),
        .blk_end_o  (blk_end)
    );

    irq_window_gen #(.WIN_DELAY(WIN_DELAY), .WIN_LEN(WIN_LEN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sd_clk_en),
        .hold    (rdwait_req),
        .arm     (blk_end && wide_mode),
        .win_o   (irq_window),
        .sample_o(win_sample)
    );

    irq_flag_core u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .xfer_active(xfer_active),
        .dat1_in    (dat1_in),
        .sample     (win_sample),
        .clear      (irq_clear),
        .pending_o  (irq_pending)
    );

    // Purpose: gate the request and forward the pause.
    always_comb begin
        irq_out   = irq_pending && irq_en;
        ctr_pause = rdwait_req;
    end

    a_r2_idle_wide_level: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && !xfer_active && !dat1_in) |=> irq_pending);
endmodule

// File: tb/sdio_irq_watch_tb.sv
module sdio_irq_watch_tb_top;
    logic clk = 1'b0;
    logic rst_n, sd_clk_en, wide_mode, dat1_in, xfer_active, byte_stb;
    logic irq_en, rdwait_req, irq_clear;
    logic irq_out, ctr_pause, irq_pending, irq_window;
    logic [8:0] byte_count;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    sdio_irq_watch dut_i (
        .clk(clk), .rst_n(rst_n), .sd_clk_en(sd_clk_en), .wide_mode(wide_mode),
        .dat1_in(dat1_in), .xfer_active(xfer_active), .byte_stb(byte_stb),
        .irq_en(irq_en), .rdwait_req(rdwait_req), .irq_clear(irq_clear),
        .irq_out(irq_out), .ctr_pause(ctr_pause), .irq_pending(irq_pending),
        .irq_window(irq_window), .byte_count(byte_count)
    );

    // Vector fields: [5]wide [4]active [3]dat1 [2]en [1]exp pending [0]exp out
    localparam logic [5:0] VECS [8] = '{
        6'b0_0_0_1_1_1,   // R1 low -> request
        6'b0_0_1_1_0_0,   // R1 high -> drops
        6'b0_1_0_1_1_1,   // R1 active does not matter
        6'b0_1_0_0_1_0,   // R9 masked
        6'b1_0_0_1_1_1,   // R2 idle wide level
        6'b1_0_1_1_0_0,   // R2 drops
        6'b1_1_0_1_0_0,   // R3 data, no window
        6'b1_0_0_1_1_1    // R2 again
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Strobe n bytes, one per cycle, then drop the strobe.
    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            step();
        end
        byte_stb = 1'b0;
    endtask

    // Finish a block with dat1 low outside the window; drive the window
    // sample point with win_dat, optional clear. Returns via checks.
    task automatic block_window(input logic win_dat, input logic clr,
                                input int exp_pend, input string req);
        dat1_in = 1'b1;
        bytes(511);
        check("R7 count at last byte", byte_count, 511);
        dat1_in = 1'b0;
        bytes(1);
        check("R7 wrap to zero", byte_count, 0);
        check("R4 window closed at boundary", irq_window, 0);
        step();
        check("R4 window closed after one tick", irq_window, 0);
        check("R3 low during delay ignored", irq_pending, 0);
        step();
        check("R4 window open after two ticks", irq_window, 1);
        dat1_in   = win_dat;
        irq_clear = clr;
        step();
        irq_clear = 1'b0;
        check("R4 window length", irq_window, 0);
        check(req, irq_pending, exp_pend);
        dat1_in = 1'b1;
        step();
        check({req, " held"}, irq_pending, exp_pend);
    endtask

    initial begin
        rst_n = 0; sd_clk_en = 1; wide_mode = 0; dat1_in = 1; xfer_active = 0;
        byte_stb = 0; irq_en = 1; rdwait_req = 0; irq_clear = 0;
        @(negedge clk); step(); step();
        rst_n = 1;
        step();
        check("reset pending", irq_pending, 0);
        check("reset out", irq_out, 0);
        check("reset count", byte_count, 0);
        check("reset window", irq_window, 0);
        check("reset pause", ctr_pause, 0);

        // Table walk: R1 R2 R3 R9 level behaviour
        foreach (VECS[k]) begin
            wide_mode = VECS[k][5]; xfer_active = VECS[k][4];
            dat1_in = VECS[k][3]; irq_en = VECS[k][2];
            step();
            check($sformatf("R1/R2/R3 vector %0d pending", k), irq_pending, VECS[k][1]);
            check($sformatf("R9 vector %0d out", k), irq_out, VECS[k][0]);
        end

        // Wide-mode blocks
        wide_mode = 1; dat1_in = 1; irq_en = 1; xfer_active = 0;
        step();
        xfer_active = 1;
        block_window(1'b1, 1'b0, 0, "R3 high in window no set");
        block_window(1'b0, 1'b0, 1, "R4 window sample sets");
        irq_en = 0;
        step();
        check("R9 masked out", irq_out, 0);
        check("R9 still pending", irq_pending, 1);
        irq_en = 1;
        irq_clear = 1;
        step();
        irq_clear = 0;
        check("R8 clear", irq_pending, 0);
        block_window(1'b0, 1'b1, 0, "R8 clear beats set");

        // Read-wait
        bytes(5);
        check("R7 count five", byte_count, 5);
        rdwait_req = 1;
        step();
        check("R5 pause out", ctr_pause, 1);
        bytes(3);
        check("R5 count held", byte_count, 5);
        xfer_active = 0;
        step();
        check("R5 held with no transfer", byte_count, 5);
        xfer_active = 1;
        rdwait_req = 0;
        bytes(1);
        check("R6 resume", byte_count, 6);
        check("R6 pause released", ctr_pause, 0);
        xfer_active = 0;
        step();
        check("R7 idle clears count", byte_count, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule